// File: doc/BRIEF.md
# Trimmed Nanosecond Time-of-Day Counter

This block keeps a free-running nanosecond time value for precision time protocol use. Each time the reference tick strobe is high the count moves forward by a fixed nominal step of 8 ns. A signed trim value is added into a 32-bit sub-nanosecond fraction on every tick. When the fraction overflows, one extra nanosecond is added. When it underflows, one nanosecond is taken away. Software can therefore pull the clock rate up or down in very fine steps without ever changing the nominal step.

Software reaches the block through a small word-wide register port with three registers. The time value is split into a low word and a narrow high word, and a read of the low word freezes the high part so that two separate reads give one consistent value. A new time is written low word first, and the high word write applies the whole value at once. The trim register holds the correction magnitude and its direction. Only 40 bits of nanoseconds are kept, so the count wraps roughly every 18.3 minutes. Extending the count past that wrap is left to software.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the nanosecond count, the fraction, the trim register, the staged low word and the frozen high part are all zero, so a read of any register (address 0 time low, 1 time high, 2 trim) returns 0.
- R2: With a trim magnitude of zero, each cycle with `tick` high adds exactly 8 to the count, and a cycle with `tick` low leaves it unchanged.
- R3: When trim bit 31 is 0, the magnitude in trim bits 30:0 is added to the 32-bit fraction on each tick; a fraction overflow makes that tick add 9 ns (magnitude 0x40000000 from a zero fraction gives 66 ns after 8 ticks).
- R4: When trim bit 31 is 1, the magnitude is subtracted from the fraction on each tick; a fraction borrow makes that tick add 7 ns (magnitude 0x40000000 from a zero fraction gives 62 ns after 8 ticks).
- R5: A write to the trim register (address 2) is used from the next tick on, never by a tick in the same cycle as the write, and reads back all 32 written bits.
- R6: A read of address 0 returns count bits 31:0 and freezes count bits 39:32; a read of address 1 returns the frozen bits in data bits 7:0 with data bits 31:8 zero, even if the count has moved since.
- R7: A write of address 0 only stages a low word and leaves the count alone; a write of address 1 sets the count to {wdata[7:0], staged low word} and clears the fraction.
- R8: When a time write to address 1 and a tick fall in the same cycle, the written value is taken and that tick is dropped.
- R9: The count wraps modulo 2^40, so 0xFF_FFFFFFFC plus one nominal tick gives 0x00_00000004.
- R10: Read data appears together with `bus_rvalid` in the cycle after `bus_rd` is sampled, and `bus_rvalid` is high only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Reference tick strobe, one count step per high cycle |
| bus_rd | input | 1 | Register read request |
| bus_wr | input | 1 | Register write request |
| bus_addr | input | 2 | Register address: 0 time low, 1 time high, 2 trim |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
The count is driven with trim of zero, a positive quarter-nanosecond trim and a negative quarter-nanosecond trim. Comparing the exact totals of 80, 66 and 62 ns tells apart a dropped carry, a carry applied in the wrong direction and a fraction that is not kept between ticks. Loads just below the 32-bit boundary and just below the 40-bit wrap show whether the frozen high part is coherent and whether the top bits are discarded. Writes that coincide with a tick show that a load wins and that a trim update waits for the next tick.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;

   // Register addresses on the software port
   typedef enum logic [1:0] {
      REG_TIME_LO = 2'd0,
      REG_TIME_HI = 2'd1,
      REG_TRIM    = 2'd2,
      REG_SPARE   = 2'd3
   } reg_sel_e;

   // Whole-nanosecond correction coming out of the fraction
   typedef struct packed {
      logic carry;
      logic borrow;
   } frac_adj_t;

endpackage

// File: rtl/ptp_frac_acc.sv
module ptp_frac_acc
   import ptp_tod_pkg::*;
#(
   parameter int FRAC_W  = 32,
   parameter bit TRIM_EN = 1'b1,
   localparam int MAG_W  = FRAC_W - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             clr,
   input  logic             trim_neg,
   input  logic [MAG_W-1:0] trim_mag,
   output frac_adj_t        adj
);

   generate
      if (TRIM_EN) begin : g_trim
         logic [FRAC_W-1:0] frac_q;
         logic [FRAC_W:0]   sum;
         logic              past_ok;

         always_comb begin
            if (trim_neg)
               sum = {1'b0, frac_q} - {2'b00, trim_mag};
            else
               sum = {1'b0, frac_q} + {2'b00, trim_mag};
         end

         always_ff @(posedge clk) begin
            if (!rst_n)
               frac_q <= '0;
            else if (clr)
               frac_q <= '0;
            else if (step_en)
               frac_q <= sum[FRAC_W-1:0];
         end

         assign adj = '{carry:  step_en & ~trim_neg & sum[FRAC_W],
                        borrow: step_en &  trim_neg & sum[FRAC_W]};

         always_ff @(posedge clk) begin
            if (!rst_n) past_ok <= 1'b0;
            else        past_ok <= 1'b1;
         end

         // R3
         carry_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && adj.carry && !clr) |=> (frac_q < $past(frac_q)));

         // R4
         borrow_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && adj.borrow && !clr) |=> (frac_q > $past(frac_q)));

         // R2
         zero_trim_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (trim_mag == '0) |-> (adj == '0));
      end else begin : g_fixed
         assign adj = '0;
      end
   endgenerate

endmodule

// File: rtl/ptp_ns_counter.sv
module ptp_ns_counter
   import ptp_tod_pkg::*;
#(
   parameter int NS_W     = 40,
   parameter int NOM_STEP = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step_en,
   input  frac_adj_t       adj,
   input  logic            load,
   input  logic [NS_W-1:0] load_val,
   output logic [NS_W-1:0] cnt
);

   localparam logic [NS_W-1:0] STEP_NOM = NS_W'(NOM_STEP);

   logic [NS_W-1:0] delta;
   logic            past_ok;

   always_comb begin
      delta = STEP_NOM;
      if (adj.carry)  delta = STEP_NOM + NS_W'(1);
      if (adj.borrow) delta = STEP_NOM - NS_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (step_en)
         cnt <= cnt + delta;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R2
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && step_en && !load) |=>
         ((cnt - $past(cnt)) >= STEP_NOM - NS_W'(1)) &&
         ((cnt - $past(cnt)) <= STEP_NOM + NS_W'(1)));

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !step_en && !load) |=> $stable(cnt));

   // R8
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && load) |=> (cnt == $past(load_val)));

endmodule

// File: rtl/ptp_reg_port.sv
module ptp_reg_port
   import ptp_tod_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int NS_W   = 40,
   localparam int HI_W  = NS_W - WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [NS_W-1:0]   cnt,
   output logic [WORD_W-1:0] rdata,
   output logic              rd_valid,
   output logic              load,
   output logic [NS_W-1:0]   load_val,
   output logic              trim_neg,
   output logic [WORD_W-2:0] trim_mag
);

   reg_sel_e          sel;
   logic [HI_W-1:0]   snap_hi;
   logic [WORD_W-1:0] stage_lo;
   logic [WORD_W-1:0] trim_q;
   logic              past_ok;

   assign sel = reg_sel_e'(addr);

   // Read side: low-word read freezes the upper part
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata    <= '0;
         rd_valid <= 1'b0;
         snap_hi  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) begin
            unique case (sel)
               REG_TIME_LO: begin
                  rdata   <= cnt[WORD_W-1:0];
                  snap_hi <= cnt[NS_W-1:WORD_W];
               end
               REG_TIME_HI: rdata <= {{(WORD_W-HI_W){1'b0}}, snap_hi};
               REG_TRIM:    rdata <= trim_q;
               default:     rdata <= '0;
            endcase
         end
      end
   end

   // Write side: staged low word, trim register
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_lo <= '0;
         trim_q   <= '0;
      end else if (wr_en) begin
         if (sel == REG_TIME_LO) stage_lo <= wdata;
         if (sel == REG_TRIM)    trim_q   <= wdata;
      end
   end

   assign load     = wr_en && (sel == REG_TIME_HI);
   assign load_val = {wdata[HI_W-1:0], stage_lo};
   assign trim_neg = trim_q[WORD_W-1];
   assign trim_mag = trim_q[WORD_W-2:0];

   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R6
   hi_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && rd_valid && $past(rd_en && sel == REG_TIME_HI)) |->
         (rdata[WORD_W-1:HI_W] == '0));

   // R6
   snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !(rd_en && sel == REG_TIME_LO)) |=> $stable(snap_hi));

endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
   import ptp_tod_pkg::*;
#(
   parameter int NS_W     = 40,
   parameter int FRAC_W   = 32,
   parameter int WORD_W   = 32,
   parameter int NOM_STEP = 8,
   parameter bit TRIM_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [1:0]        bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic              bus_rvalid
);

   localparam int MAG_W = FRAC_W - 1;

   generate
      if (FRAC_W != WORD_W) begin : g_bad_frac
         $error("fraction width must equal word width");
      end
      if (NS_W <= WORD_W || NS_W > 2 * WORD_W) begin : g_bad_ns
         $error("count width must lie between one and two words");
      end
      if (NOM_STEP < 2) begin : g_bad_step
         $error("nominal step must be at least 2");
      end
   endgenerate

   logic             load;
   logic [NS_W-1:0]  load_val;
   logic [NS_W-1:0]  cnt;
   logic             trim_neg;
   logic [MAG_W-1:0] trim_mag;
   logic             step_en;
   frac_adj_t        adj;

   // A time load in the same cycle suppresses the tick
   assign step_en = tick & ~load;

   ptp_reg_port #(
      .WORD_W (WORD_W),
      .NS_W   (NS_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (bus_rd),
      .wr_en    (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .cnt      (cnt),
      .rdata    (bus_rdata),
      .rd_valid (bus_rvalid),
      .load     (load),
      .load_val (load_val),
      .trim_neg (trim_neg),
      .trim_mag (trim_mag)
   );

   ptp_frac_acc #(
      .FRAC_W  (FRAC_W),
      .TRIM_EN (TRIM_EN)
   ) u_frac (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (step_en),
      .clr      (load),
      .trim_neg (trim_neg),
      .trim_mag (trim_mag),
      .adj      (adj)
   );

   ptp_ns_counter #(
      .NS_W     (NS_W),
      .NOM_STEP (NOM_STEP)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (step_en),
      .adj      (adj),
      .load     (load),
      .load_val (load_val),
      .cnt      (cnt)
   );

   // R10
   rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_rd));

endmodule

// File: tb/tb_ptp_tod_counter.sv
module tb_ptp_tod_counter;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   // Reference model state, kept from the requirements
   logic [39:0] m_cnt;
   logic [31:0] m_frac, m_trim, m_stage;
   logic [7:0]  m_snap;
   logic [32:0] m_sum;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptp_tod_counter dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = '0; m_frac = '0; m_trim = '0; m_stage = '0; m_snap = '0;
      end else begin
         if (bus_rd && bus_addr == 2'd0) m_snap = m_cnt[39:32];
         if (bus_wr && bus_addr == 2'd1) begin
            m_cnt  = {bus_wdata[7:0], m_stage};
            m_frac = '0;
         end else if (tick) begin
            if (m_trim[31]) m_sum = {1'b0, m_frac} - {2'b00, m_trim[30:0]};
            else            m_sum = {1'b0, m_frac} + {2'b00, m_trim[30:0]};
            m_frac = m_sum[31:0];
            m_cnt  = m_cnt + 40'd8;
            if (m_sum[32] && !m_trim[31]) m_cnt = m_cnt + 40'd1;
            if (m_sum[32] &&  m_trim[31]) m_cnt = m_cnt - 40'd1;
         end
         if (bus_wr && bus_addr == 2'd0) m_stage = bus_wdata;
         if (bus_wr && bus_addr == 2'd2) m_trim  = bus_wdata;
      end
   end

   // Monitor: pops expected reads as the design returns them (R10)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL R10: rvalid with no read pending, actual rdata=%h expected none", bus_rdata);
            end else begin
               logic [31:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               if (bus_rdata !== e) begin
                  fails++;
                  $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
               end
            end
         end
      end
   end

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_push(input logic [1:0] a, input logic [31:0] e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   // Expected value taken from the model
   task automatic rd_model(input logic [1:0] a, input string t);
      logic [31:0] e;
      if (a == 2'd0)      e = m_cnt[31:0];
      else if (a == 2'd1) e = {24'd0, m_snap};
      else                e = m_trim;
      rd_push(a, e, t);
   endtask

   task automatic ticks(input int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic set_time(input logic [39:0] v);
      wr_reg(2'd0, v[31:0]);
      wr_reg(2'd1, {24'd0, v[39:32]});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      rd_push(2'd0, 32'd0, "R1 time low");
      rd_push(2'd1, 32'd0, "R1 time high");
      rd_push(2'd2, 32'd0, "R1 trim");

      // R2: nominal step and hold
      ticks(10);
      rd_push(2'd0, 32'd80, "R2 ten nominal ticks");
      repeat (5) @(negedge clk);
      rd_push(2'd0, 32'd80, "R2 hold without tick");

      // R3: positive trim, quarter ns
      wr_reg(2'd2, 32'h4000_0000);
      set_time(40'd0);
      ticks(8);
      rd_push(2'd0, 32'd66, "R3 positive trim total");
      rd_push(2'd2, 32'h4000_0000, "R5 trim readback");
      ticks(5);
      rd_model(2'd0, "R3 positive trim continued");

      // R4: negative trim, quarter ns
      wr_reg(2'd2, 32'hC000_0000);
      set_time(40'd0);
      ticks(8);
      rd_push(2'd0, 32'd62, "R4 negative trim total");
      rd_push(2'd2, 32'hC000_0000, "R5 signed trim readback");

      // R7: staging does not disturb count; high write loads
      wr_reg(2'd2, 32'd0);
      wr_reg(2'd0, 32'h1234_5678);
      rd_push(2'd0, 32'd62, "R7 staged low not applied");
      wr_reg(2'd1, 32'hFFFF_FFAB);
      rd_push(2'd0, 32'h1234_5678, "R7 loaded low word");
      rd_push(2'd1, 32'h0000_00AB, "R6 high word padded with zeros");

      // R6: coherent split read across the 32-bit boundary
      set_time(40'h00_FFFF_FFF8);
      rd_push(2'd0, 32'hFFFF_FFF8, "R6 low before boundary");
      ticks(1);
      rd_push(2'd1, 32'd0, "R6 frozen high after count crossed");
      rd_push(2'd0, 32'd0, "R6 low after boundary");
      rd_push(2'd1, 32'd1, "R6 new frozen high");

      // R8: load and tick in the same cycle
      wr_reg(2'd0, 32'd100);
      tick = 1'b1;
      wr_reg(2'd1, 32'd0);
      tick = 1'b0;
      rd_push(2'd0, 32'd100, "R8 load beats tick");

      // R9: wrap of the 40-bit count
      set_time(40'hFF_FFFF_FFFC);
      ticks(1);
      rd_push(2'd0, 32'd4, "R9 low after wrap");
      rd_push(2'd1, 32'd0, "R9 high after wrap");

      // R5: trim written in a tick cycle is not used by that tick
      set_time(40'd0);
      tick = 1'b1;
      wr_reg(2'd2, 32'hFFFF_FFFF);
      tick = 1'b0;
      rd_push(2'd0, 32'd8, "R5 trim not used same cycle");
      ticks(1);
      rd_push(2'd0, 32'd15, "R5 trim used on next tick");

      // Mixed run against the model
      wr_reg(2'd2, 32'h1234_5677);
      ticks(37);
      rd_model(2'd0, "R3 mixed trim low");
      rd_model(2'd1, "R6 mixed trim high");

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R10: reads unanswered actual=%0d expected=0", exp_q.size());
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule